// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block performs the architectural bookkeeping a processor core needs when it enters an interrupt handler or leaves one. Each cycle it looks at three cause inputs: a system-call request, a coprocessor claiming the decoded instruction, and a timer request. It also reads the current instruction address, the next sequential address, the machine state word and a 16-bit vector prefix. When a cause is taken, the block records two things in two save registers: the address at which execution should later resume, and the full old state word. It then produces a new state word, with a fixed set of bits cleared, and a new program counter at the handler vector.

A return strobe does the reverse. It reloads the program counter from the first save register and the state word from the second. Fetch, decode and the pipeline sit outside this block. The core samples `redirect` and loads `pc_out` and `state_out` when it sees it. `taken` and `cause` mark every entry.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pc_out`, `state_out`, `save0`, `save1`, `cause`, `taken` and `redirect` are all zero. A reset at any time clears both save registers.
- R2: A system-call entry writes `next_pc` into `save0` and vectors to offset 0x0C00.
- R3: The coprocessor-unavailable cause is raised only when `cop_claim` is 1 and state bit 25 (bit 6 in big-endian numbering) is 0. On that entry `save0` receives `cur_pc`. `inhibit_exec` is high combinationally in the same cycle.
- R4: The timer cause is raised only when `timer_req` is 1 and state bit 15 (bit 16 in big-endian numbering) is 1. It writes `next_pc` into `save0` and vectors to offset 0x1000.
- R5: Every entry writes the complete old `state_in` into `save1`.
- R6: On entry, `state_out` equals the old state with every bit of mask 0x020CED30 cleared. All other bits, including bits 17, 12 and 9, keep their values.
- R7: On entry, `pc_out` is `{vec_prefix, offset}`, where the offset is 0x0F20 for the coprocessor cause.
- R8: Priority is coprocessor first, then system call, then timer. The cycle after an entry, `taken` and `redirect` are 1 for one cycle and `cause` reads 1 (coprocessor), 2 (system call) or 3 (timer). Without an entry `cause` reads 0.
- R9: A return strobe with no cause pending loads `pc_out` from `save0` and `state_out` from `save1` in the following cycle. `redirect` pulses, `taken` stays 0, and both save registers are left unchanged.
- R10: When a cause and the return strobe arrive in the same cycle, the entry is performed and the return is ignored.
- R11: In a cycle with neither a cause nor a return, `pc_out`, `state_out` and both save registers hold their values, and `redirect` and `taken` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| syscall_req | input | 1 | System-call instruction is executing |
| cop_claim | input | 1 | Coprocessor claims the decoded instruction |
| timer_req | input | 1 | Timer time-out pending |
| ret_strobe | input | 1 | Return-from-interrupt request |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next sequential instruction |
| state_in | input | 32 | Current machine state word |
| vec_prefix | input | 16 | Upper half of every handler address |
| inhibit_exec | output | 1 | Current instruction must not execute |
| redirect | output | 1 | Load `pc_out` and `state_out` this cycle |
| taken | output | 1 | An entry was performed |
| cause | output | 2 | Code of the cause taken |
| pc_out | output | 32 | New program counter |
| state_out | output | 32 | New machine state word |
| save0 | output | 32 | Saved resume address |
| save1 | output | 32 | Saved machine state word |

## Verification
The hardest situations to reach are the ones that combine several inputs in one cycle. These are overlapping causes, a coprocessor claim or timer request that the state word suppresses, and a return strobe that collides with an entry. A table of rows reaches them by driving chosen combinations of the three causes against state words that enable or disable the gated causes. Directed sequences then place a return strobe directly after reset, after an entry, and together with a system call. Those sequences also move the vector prefix and reset the block in the middle of the run.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_COPRO   = 2'd1,
    CAUSE_SYSCALL = 2'd2,
    CAUSE_TIMER   = 2'd3
  } cause_e;

  // request index order is also priority order: index 0 wins
  localparam int unsigned IDX_COPRO   = 0;
  localparam int unsigned IDX_SYSCALL = 1;
  localparam int unsigned IDX_TIMER   = 2;
  localparam int unsigned NUM_CAUSE   = 3;
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // seen[i] is set when some lower-index (higher priority) request is active
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  assign any = seen[N];
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned N     = 3,
  parameter logic [N*OFF_W-1:0] OFFSETS = '0
) (
  input  logic [XLEN-OFF_W-1:0] prefix,
  input  logic [N-1:0]          sel,
  output logic [XLEN-1:0]       vec
);
  logic [OFF_W-1:0] part [N+1];
  assign part[0] = '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_off
      assign part[i+1] = part[i] | (OFFSETS[i*OFF_W +: OFF_W] & {OFF_W{sel[i]}});
    end
  endgenerate

  assign vec = {prefix, part[N]};
endmodule

// File: rtl/exc_save.sv
module exc_save #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ret_addr,
  input  logic [W-1:0] old_state,
  output logic [W-1:0] q_addr,
  output logic [W-1:0] q_state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr  <= '0;
      q_state <= '0;
    end else if (load) begin
      q_addr  <= ret_addr;
      q_state <= old_state;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned COP_BIT   = 25,
  parameter int unsigned EE_BIT    = 15,
  parameter logic [XLEN-1:0] CLEAR_MASK  = 32'h020C_ED30,
  parameter logic [OFF_W-1:0] OFF_COPRO   = 16'h0F20,
  parameter logic [OFF_W-1:0] OFF_SYSCALL = 16'h0C00,
  parameter logic [OFF_W-1:0] OFF_TIMER   = 16'h1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  syscall_req,
  input  logic                  cop_claim,
  input  logic                  timer_req,
  input  logic                  ret_strobe,
  input  logic [XLEN-1:0]       cur_pc,
  input  logic [XLEN-1:0]       next_pc,
  input  logic [XLEN-1:0]       state_in,
  input  logic [XLEN-OFF_W-1:0] vec_prefix,
  output logic                  inhibit_exec,
  output logic                  redirect,
  output logic                  taken,
  output logic [1:0]            cause,
  output logic [XLEN-1:0]       pc_out,
  output logic [XLEN-1:0]       state_out,
  output logic [XLEN-1:0]       save0,
  output logic [XLEN-1:0]       save1
);
  import exc_pkg::*;

  localparam int unsigned NC = NUM_CAUSE;
  localparam logic [NC*OFF_W-1:0] OFFS = {OFF_TIMER, OFF_SYSCALL, OFF_COPRO};

  logic [NC-1:0]   req, gnt;
  logic            any;
  logic [XLEN-1:0] vec;
  logic [XLEN-1:0] resume_addr;
  logic            ret_fire;
  cause_e          cause_nxt;

  // cause qualification against the state word
  assign req[IDX_COPRO]   = cop_claim & ~state_in[COP_BIT];
  assign req[IDX_SYSCALL] = syscall_req;
  assign req[IDX_TIMER]   = timer_req & state_in[EE_BIT];

  exc_prio #(.N(NC)) u_prio (
    .req (req),
    .gnt (gnt),
    .any (any)
  );

  exc_vector #(.XLEN(XLEN), .OFF_W(OFF_W), .N(NC), .OFFSETS(OFFS)) u_vec (
    .prefix (vec_prefix),
    .sel    (gnt),
    .vec    (vec)
  );

  // faulting instruction resumes itself; the others resume after
  assign resume_addr  = gnt[IDX_COPRO] ? cur_pc : next_pc;
  assign inhibit_exec = gnt[IDX_COPRO];
  assign ret_fire     = ret_strobe & ~any;

  always_comb begin
    cause_nxt = CAUSE_NONE;
    if (gnt[IDX_COPRO])        cause_nxt = CAUSE_COPRO;
    else if (gnt[IDX_SYSCALL]) cause_nxt = CAUSE_SYSCALL;
    else if (gnt[IDX_TIMER])   cause_nxt = CAUSE_TIMER;
  end

  exc_save #(.W(XLEN)) u_save (
    .clk       (clk),
    .rst       (rst),
    .load      (any),
    .ret_addr  (resume_addr),
    .old_state (state_in),
    .q_addr    (save0),
    .q_state   (save1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out    <= '0;
      state_out <= '0;
      redirect  <= 1'b0;
      taken     <= 1'b0;
      cause     <= CAUSE_NONE;
    end else begin
      redirect <= any | ret_fire;
      taken    <= any;
      cause    <= cause_nxt;
      if (any) begin
        pc_out    <= vec;
        state_out <= state_in & ~CLEAR_MASK;
      end else if (ret_fire) begin
        pc_out    <= save0;
        state_out <= save1;
      end
    end
  end

  // R5: the old state word is captured in full
  assert_save_state_R5: assert property (@(posedge clk) disable iff (rst)
    any |=> (save1 == $past(state_in)));

  // R6: masked bits clear, the rest carried through
  assert_clear_mask_R6: assert property (@(posedge clk) disable iff (rst)
    any |=> (((state_out & CLEAR_MASK) == '0) &&
             ((state_out & ~CLEAR_MASK) == ($past(state_in) & ~CLEAR_MASK))));

  // R7: handler address keeps the prefix in the upper half
  assert_vec_prefix_R7: assert property (@(posedge clk) disable iff (rst)
    any |=> (pc_out[XLEN-1:OFF_W] == $past(vec_prefix)));

  // R3: coprocessor fault resumes at the faulting instruction
  assert_copro_resume_R3: assert property (@(posedge clk) disable iff (rst)
    (any && cause_nxt == CAUSE_COPRO) |=> (save0 == $past(cur_pc)));

  // R9: return reloads from the save registers
  assert_return_R9: assert property (@(posedge clk) disable iff (rst)
    ret_fire |=> ((pc_out == $past(save0)) && (state_out == $past(save1)) && !taken && redirect));

  // R11: idle cycles hold state
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!any && !ret_strobe) |=> ($stable(pc_out) && $stable(state_out) && $stable(save0) && !redirect));
endmodule

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam logic [31:0] MASK = 32'h020C_ED30;

  typedef struct packed {
    logic        sc;
    logic        cl;
    logic        tm;
    logic [31:0] st;
    logic [31:0] cur;
    logic [31:0] nxt;
    logic [1:0]  ec;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_1004, 2'd2},
    '{1'b0, 1'b1, 1'b0, 32'hFDFF_FFFF, 32'h0000_2000, 32'h0000_2004, 2'd1},
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_3000, 32'h0000_3004, 2'd0},
    '{1'b0, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_4000, 32'h0000_4004, 2'd3},
    '{1'b0, 1'b0, 1'b1, 32'hFFFF_7FFF, 32'h0000_5000, 32'h0000_5004, 2'd0},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_6000, 32'h0000_6004, 2'd1},
    '{1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_7000, 32'h0000_7004, 2'd2},
    '{1'b0, 1'b1, 1'b1, 32'h0000_8000, 32'h0000_8000, 32'h0000_8004, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        syscall_req = 1'b0, cop_claim = 1'b0, timer_req = 1'b0, ret_strobe = 1'b0;
  logic [31:0] cur_pc = '0, next_pc = '0, state_in = '0;
  logic [15:0] vec_prefix = 16'h8000;
  logic        inhibit_exec, redirect, taken;
  logic [1:0]  cause;
  logic [31:0] pc_out, state_out, save0, save1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] last_pc, last_st, last_s0, last_s1;

  always #4 clk = ~clk;

  exc_ctrl dut (
    .clk(clk), .rst(rst), .syscall_req(syscall_req), .cop_claim(cop_claim),
    .timer_req(timer_req), .ret_strobe(ret_strobe), .cur_pc(cur_pc),
    .next_pc(next_pc), .state_in(state_in), .vec_prefix(vec_prefix),
    .inhibit_exec(inhibit_exec), .redirect(redirect), .taken(taken),
    .cause(cause), .pc_out(pc_out), .state_out(state_out),
    .save0(save0), .save1(save1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] offset_of(input logic [1:0] ec);
    case (ec)
      2'd1:    return 16'h0F20;
      2'd2:    return 16'h0C00;
      default: return 16'h1000;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    syscall_req = 1'b0; cop_claim = 1'b0; timer_req = 1'b0; ret_strobe = 1'b0;
  endtask

  task automatic snapshot();
    last_pc = pc_out; last_st = state_out; last_s0 = save0; last_s1 = save1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pc_out", pc_out, 32'h0);
    check("R1 state_out", state_out, 32'h0);
    check("R1 save0", save0, 32'h0);
    check("R1 save1", save1, 32'h0);
    check("R1 flags", {29'h0, taken, redirect, |cause}, 32'h0);
    rst = 1'b0;
    tick();
    check("R1 after release", {29'h0, taken, redirect, |cause}, 32'h0);

    // R9: return straight after reset reloads the cleared save registers
    ret_strobe = 1'b1;
    tick();
    idle_inputs();
    check("R9 ret after reset pc", pc_out, 32'h0);
    check("R9 ret after reset redirect/taken", {30'h0, redirect, taken}, 32'h2);
    snapshot();

    // table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < 8; i++) begin
      syscall_req = TBL[i].sc; cop_claim = TBL[i].cl; timer_req = TBL[i].tm;
      state_in = TBL[i].st; cur_pc = TBL[i].cur; next_pc = TBL[i].nxt;
      #1;
      check($sformatf("R3 inhibit row %0d", i), {31'h0, inhibit_exec},
            {31'h0, TBL[i].cl & ~TBL[i].st[25]});
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      check($sformatf("R8 cause row %0d", i), {30'h0, cause}, {30'h0, TBL[i].ec});
      if (TBL[i].ec != 2'd0) begin
        check($sformatf("R8 taken row %0d", i), {30'h0, taken, redirect}, 32'h3);
        check($sformatf("R7 pc row %0d", i), pc_out, {vec_prefix, offset_of(TBL[i].ec)});
        check($sformatf("R6 state row %0d", i), state_out, TBL[i].st & ~MASK);
        check($sformatf("R5 save1 row %0d", i), save1, TBL[i].st);
        check($sformatf("R2/R3/R4 save0 row %0d", i), save0,
              (TBL[i].ec == 2'd1) ? TBL[i].cur : TBL[i].nxt);
      end else begin
        check($sformatf("R3/R4 suppressed taken row %0d", i), {30'h0, taken, redirect}, 32'h0);
        check($sformatf("R11 pc hold row %0d", i), pc_out, last_pc);
        check($sformatf("R11 state hold row %0d", i), state_out, last_st);
        check($sformatf("R11 save0 hold row %0d", i), save0, last_s0);
        check($sformatf("R11 save1 hold row %0d", i), save1, last_s1);
      end
      snapshot();
      tick();
      check($sformatf("R8 pulse ends row %0d", i), {30'h0, taken, redirect}, 32'h0);
      check($sformatf("R11 idle pc row %0d", i), pc_out, last_pc);
    end

    // R9: return after the last entry (coprocessor, row 7)
    state_in = 32'h1234_5678;
    ret_strobe = 1'b1;
    tick();
    idle_inputs();
    check("R9 return pc", pc_out, 32'h0000_8000);
    check("R9 return state", state_out, 32'h0000_8000);
    check("R9 return flags", {30'h0, redirect, taken}, 32'h2);
    check("R9 save0 unchanged", save0, last_s0);
    check("R9 save1 unchanged", save1, last_s1);

    // R10: entry and return in the same cycle
    syscall_req = 1'b1; ret_strobe = 1'b1;
    state_in = 32'hAAAA_5555; next_pc = 32'h0000_9004; cur_pc = 32'h0000_9000;
    tick();
    idle_inputs();
    check("R10 cause", {30'h0, cause}, 32'h2);
    check("R10 pc", pc_out, {16'h8000, 16'h0C00});
    check("R10 save0", save0, 32'h0000_9004);
    check("R10 state", state_out, 32'hAAAA_5555 & ~MASK);

    // R7: new prefix
    vec_prefix = 16'hABCD;
    timer_req = 1'b1; state_in = 32'h0000_8000;
    tick();
    idle_inputs();
    check("R7 new prefix timer", pc_out, 32'hABCD_1000);
    check("R4 timer save0", save0, 32'h0000_9004);

    // R1: reset in the middle clears save registers
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 mid reset save0", save0, 32'h0);
    check("R1 mid reset save1", save1, 32'h0);
    check("R1 mid reset pc", pc_out, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule